// File: doc/BRIEF.md
# Scheduled Battery Health Checker

This controller decides when the backup cell gets measured and keeps the outcome in a status byte. A check starts each time the main supply comes back. Another check starts after a fixed number of one-second ticks. While a check runs, the block raises a request line so that the external comparator is powered. It waits a set number of ticks for that comparator to settle. It then samples the comparator's "low" output once and writes the result into a battery-low flag.

Between checks the flag holds its value. Only a completed check can change it, so nothing the comparator does in between has any effect. The block never measures while it is running from the backup cell. If the main supply fails partway through a check, that check is dropped and leaves no trace. A second status bit records which kind of check produced the most recent low result. Software reads both bits through a small address/data read port.

Top module: `batt_chk_ctrl`

States of the sequencer: `ST_OFF` (main supply absent), `ST_IDLE` (supply good, waiting), `ST_SETTLE` (request raised, counting settle ticks), `ST_SAMPLE` (one clock, comparator captured). Transitions: OFF→SETTLE when the supply is good (power-up check). IDLE→SETTLE when the interval counter expires (periodic check). SETTLE→SAMPLE on the last settle tick. SAMPLE→IDLE after the capture. Any state→OFF when the supply is not good (abort).

## Requirements
- R1: After reset, `chk_req` is 0 and reading address 0xF returns 0 (flag clear, source bit clear).
- R2: When `supply_ok` is sampled high while the block is off, `chk_req` is 1 in the following cycle (power-up check).
- R3: `chk_req` stays 1 through `SETTLE_TICKS` tick pulses and for exactly one further clock, and is 0 in the clock after that.
- R4: At the end of a completed check, the battery-low flag becomes the value of `cmp_low` sampled in the last clock that `chk_req` is high.
- R5: With the supply held good, a periodic check starts (`chk_req` 1 in the next cycle) on the `INTERVAL_TICKS`-th tick counted from the supply's rise. `chk_req` stays 0 on all earlier ticks.
- R6: If `supply_ok` is sampled low, `chk_req` is 0 in the next cycle, whatever the state.
- R7: If `supply_ok` falls during a check, including its sample clock, the flag and source bit keep their previous values.
- R8: Changes on `cmp_low` outside the sample clock do not change the flag.
- R9: When a check records a low result, the source bit becomes 0 for a power-up check and 1 for a periodic check. A good result leaves the source bit unchanged.
- R10: Reading address 0xF returns the flag at bit 4 and the source bit at bit 0, with all other bits 0. Every other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse per second |
| supply_ok | input | 1 | Main supply is at nominal level |
| cmp_low | input | 1 | Comparator reports the cell below threshold |
| rd_addr | input | ADDR_W | Status read address |
| chk_req | output | 1 | Measurement request to the comparator |
| rd_data | output | DATA_W | Status read data |

## Verification
Comparator values are randomised. They are also toggled between checks, which separates a flag that only follows completed checks from one that tracks the live input. Power-up checks and interval checks are mixed, so the source bit has to follow the check kind, and a good result has to leave that bit alone. Supply drops are placed at every settle tick and at the sample clock. These show whether an aborted check leaves the stored state untouched and whether the request stops at once. The interval check is timed tick by tick from the supply's rise, which exposes off-by-one errors in both counters.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_SAMPLE = 2'd3
    } bcc_state_e;

    typedef enum logic {
        SRC_PWRUP    = 1'b0,
        SRC_PERIODIC = 1'b1
    } bcc_src_e;

    localparam int FLAG_BIT = 4;
    localparam int SRC_BIT  = 0;
endpackage

// File: rtl/bcc_interval.sv
module bcc_interval #(
    parameter int INTERVAL_TICKS = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    output logic due
);
    localparam int CNT_W = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    assign due = supply_ok && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R5
    AST_CNT_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> cnt == '0); // R5
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
    import bcc_pkg::*;
#(
    parameter int SETTLE_TICKS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     supply_ok,
    input  logic     due,
    output logic     chk_req,
    output logic     upd_en,
    output bcc_src_e upd_src
);
    localparam int SC_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_TICKS - 1);

    bcc_state_e state, state_nx;
    bcc_src_e   kind, kind_nx;
    logic [SC_W-1:0] sc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            kind  <= SRC_PWRUP;
        end else begin
            state <= state_nx;
            kind  <= kind_nx;
        end
    end

    always_comb begin
        state_nx = state;
        kind_nx  = kind;
        unique case (state)
            ST_OFF: begin
                if (supply_ok) begin
                    state_nx = ST_SETTLE;
                    kind_nx  = SRC_PWRUP;
                end
            end
            ST_IDLE: begin
                if (!supply_ok) begin
                    state_nx = ST_OFF;
                end else if (due) begin
                    state_nx = ST_SETTLE;
                    kind_nx  = SRC_PERIODIC;
                end
            end
            ST_SETTLE: begin
                if (!supply_ok)                state_nx = ST_OFF;
                else if (tick && sc == SC_LAST) state_nx = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                state_nx = supply_ok ? ST_IDLE : ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SETTLE) begin
            sc <= '0;
        end else if (tick) begin
            sc <= sc + 1'b1;
        end
    end

    always_comb begin
        chk_req = (state == ST_SETTLE) || (state == ST_SAMPLE);
        upd_en  = (state == ST_SAMPLE) && supply_ok;
        upd_src = kind;
    end

    AST_NO_REQ_ON_BATTERY: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !chk_req); // R6
    AST_PWRUP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |=> chk_req); // R2
    AST_SAMPLE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SAMPLE |=> state != ST_SAMPLE); // R3
endmodule

// File: rtl/bcc_status.sv
module bcc_status
    import bcc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int STAT_ADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  bcc_src_e          upd_src,
    input  logic              cmp_low,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic     flag;
    bcc_src_e src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            src  <= SRC_PWRUP;
        end else if (upd_en) begin
            flag <= cmp_low;
            if (cmp_low) src <= upd_src;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(STAT_ADDR)) begin
            rd_data[FLAG_BIT] = flag;
            rd_data[SRC_BIT]  = src;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(flag)); // R8
    AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(src)); // R7
endmodule

// File: rtl/batt_chk_ctrl.sv
module batt_chk_ctrl
    import bcc_pkg::*;
#(
    parameter int INTERVAL_TICKS = 86400,
    parameter int SETTLE_TICKS   = 4,
    parameter int ADDR_W         = 4,
    parameter int DATA_W         = 8,
    parameter int STAT_ADDR      = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              supply_ok,
    input  logic              cmp_low,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              chk_req,
    output logic [DATA_W-1:0] rd_data
);
    logic     due;
    logic     upd_en;
    bcc_src_e upd_src;

    bcc_interval #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .due(due)
    );

    bcc_seq #(.SETTLE_TICKS(SETTLE_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok), .due(due),
        .chk_req(chk_req), .upd_en(upd_en), .upd_src(upd_src)
    );

    bcc_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)) u_status (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_src(upd_src),
        .cmp_low(cmp_low), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/tb_batt_chk_ctrl.sv
module tb_batt_chk_ctrl;
    localparam int INTERVAL = 24;
    localparam int SETTLE   = 3;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_ok = 1'b0;
    logic cmp_low = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic chk_req;
    logic [DW-1:0] rd_data;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    bit exp_flag = 0;
    bit exp_src = 0;
    bit sup_up = 0;
    int ticks_since = 0;

    batt_chk_ctrl #(.INTERVAL_TICKS(INTERVAL), .SETTLE_TICKS(SETTLE),
                    .ADDR_W(AW), .DATA_W(DW), .STAT_ADDR(15)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .cmp_low(cmp_low), .rd_addr(rd_addr), .chk_req(chk_req), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic int exp_rd(bit f, bit s);
        return (int'(f) << 4) | int'(s);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_status(input string req);
        rd_addr = 4'hF;
        #1;
        chk(req, int'(rd_data), exp_rd(exp_flag, exp_src));
        rd_addr = 4'($urandom_range(0, 14));
        #1;
        chk("R10", int'(rd_data), 0);
        rd_addr = 4'hF;
    endtask

    task automatic tick_pulse();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        ticks_since = (ticks_since + 1) % INTERVAL;
    endtask

    task automatic do_abort();
        supply_ok = 1'b0;
        sup_up = 0;
        @(negedge clk);
        chk("R6", int'(chk_req), 0);
        chk_status("R7");
    endtask

    // settle phase plus result; returns early on abort
    task automatic run_check(input bit c, input bit periodic, input int abort_at);
        for (int i = 0; i < SETTLE; i++) begin
            if (i == abort_at) begin
                do_abort();
                return;
            end
            if (i == SETTLE - 1) cmp_low = c;
            else cmp_low = 1'($urandom);
            tick_pulse();
            chk("R3", int'(chk_req), 1);
        end
        if (abort_at == SETTLE) begin
            do_abort();
            return;
        end
        @(negedge clk);
        chk("R3", int'(chk_req), 0);
        exp_flag = c;
        if (c) exp_src = periodic;
        chk_status(periodic ? "R9" : "R4");
        for (int k = 0; k < 3; k++) begin
            cmp_low = ~c;
            @(negedge clk);
            chk_status("R8");
        end
    endtask

    task automatic pwrup_check(input bit c, input int abort_at);
        if (sup_up) begin
            supply_ok = 1'b0;
            @(negedge clk);
            chk("R6", int'(chk_req), 0);
        end
        supply_ok = 1'b1;
        sup_up = 1;
        ticks_since = 0;
        cmp_low = 1'($urandom);
        @(negedge clk);
        chk("R2", int'(chk_req), 1);
        run_check(c, 1'b0, abort_at);
    endtask

    task automatic periodic_check(input bit c);
        int n;
        n = INTERVAL - ticks_since;
        for (int k = 1; k <= n; k++) begin
            cmp_low = 1'($urandom);
            tick_pulse();
            if (k < n) begin
                if (chk_req !== 1'b0) chk("R5", int'(chk_req), 0);
            end else begin
                chk("R5", int'(chk_req), 1);
            end
        end
        run_check(c, 1'b1, -1);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(chk_req), 0);
        chk_status("R1");

        // directed corners
        pwrup_check(1'b1, -1);   // low at power-up, src 0
        periodic_check(1'b0);    // periodic good clears flag, src kept
        periodic_check(1'b1);    // periodic low sets src 1
        pwrup_check(1'b0, 1);    // abort mid settle
        pwrup_check(1'b0, SETTLE); // abort at sample clock
        pwrup_check(1'b1, 0);    // abort before first tick
        pwrup_check(1'b0, -1);   // power-up good clears

        // randomized mix
        for (int t = 0; t < 40; t++) begin
            int kind;
            bit c;
            kind = $urandom_range(0, 2);
            c = 1'($urandom);
            if (kind == 0 && sup_up) periodic_check(c);
            else if (kind == 1) pwrup_check(c, $urandom_range(0, SETTLE));
            else pwrup_check(c, -1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end
endmodule